// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for integer loads and stores in a 32-bit RISC pipeline. Each operation arrives as a single-cycle request carrying an addressing-mode code, a load/store flag, two register operand values, the current program counter, a 16-bit immediate field, a 2-bit index scale and an access-size code. The block adds the two terms that the selected mode calls for and checks the combination against the pipeline's rules. One clock later it presents the address, a valid flag, an illegal-combination flag and a misalignment flag.

Three modes are provided. The first adds a sign-extended displacement to a base register. The second adds the word-scaled displacement to the program counter. The third adds a base register to an index register that can be shifted left by 0 to 3 bit positions. The adder only ever has two inputs, so no mode sums two registers with an immediate. A store is accepted only in the displacement mode, because an indexed store would need a third register read port. When either flag is raised the result still goes out with the valid flag set, so the next stage can take an exception for that operation.

Control is a two-state output machine. `OS_EMPTY` means no result is held and `OS_FULL` means a result is being presented. The transition `take` (request strobe high) moves the machine to `OS_FULL` from either state. The transition `drain` (strobe low) moves it to `OS_EMPTY` from either state. Reset forces `OS_EMPTY`.

Top module: `ldst_addr_gen`

## Requirements
- R1: Mode code 0 (displacement) produces base + sign-extended imm16. A zero immediate is legal and yields the base unchanged.
- R2: Mode code 1 (PC-relative) produces pc + (sign-extended imm16 shifted left by 2). It is legal only for a load of size code 2 (word); a store or any other size raises the illegal flag.
- R3: Mode code 2 (indexed) produces base + (index << scale), where scale is 0 to 3. The immediate has no effect on the address in this mode.
- R4: An indexed store (mode code 2 with the store flag at 1) raises the illegal flag.
- R5: Mode code 3 and size code 3 are reserved. Either one raises the illegal flag.
- R6: The displacement mode is legal for both loads and stores at size codes 0 (byte), 1 (halfword) and 2 (word).
- R7: The misalignment flag is raised for size code 1 when address bit 0 is 1, and for size code 2 when address bits 1:0 are not both 0. It is never raised for size codes 0 and 3. The address is output in every case.
- R8: Every sum wraps modulo 2^32, and the carry out is discarded.
- R9: The output valid flag equals the request strobe of the previous clock. The address changes only on a cycle after an accepted request.
- R10: A synchronous active-high reset clears the output valid flag, both error flags and the address.
- R11: A raised error flag is accompanied by the valid flag. Both error flags are low whenever the valid flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | Addressing mode: 0 displacement, 1 PC-relative, 2 indexed, 3 reserved |
| in_store | input | 1 | 1 for a store, 0 for a load |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_pc | input | 32 | Program counter of the operation |
| in_imm | input | 16 | Immediate displacement field |
| in_scale | input | 2 | Index left-shift amount, 0 to 3 |
| in_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word, 3 reserved |
| out_addr | output | 32 | Registered effective address |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_illegal | output | 1 | Illegal mode/operation/size combination |
| out_misalign | output | 1 | Address not aligned to the access size |

## Verification
The bound checker tests the following on every cycle:
- the valid flag follows the request strobe by one clock;
- the error flags are quiet when no result is presented;
- an indexed store is always flagged;
- displacement operations of a defined size are never flagged;
- the displacement sum matches the registered inputs;
- the word misalignment flag agrees with the low bits of the presented address.

The bench scenarios are what show the address arithmetic for the PC-relative and scaled indexed modes. They also cover the reserved codes, wrap-around at the top of the address space, the immediate having no effect in indexed mode, the address holding across idle cycles, and the reset values. These are checked both in directed corner cases and in seeded random operations.

// File: rtl/ldst_addr_gen_pkg.sv
package ldst_addr_gen_pkg;

    typedef enum logic [1:0] {
        AM_DISP  = 2'd0,
        AM_PCREL = 2'd1,
        AM_INDEX = 2'd2,
        AM_RSVD  = 2'd3
    } addr_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic {
        OS_EMPTY = 1'b0,
        OS_FULL  = 1'b1
    } out_state_e;

endpackage

// File: rtl/ldst_operand_sel.sv
module ldst_operand_sel
    import ldst_addr_gen_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 16,
    parameter int SCALE_W = 2,
    parameter int PC_SH   = 2
) (
    input  addr_mode_e         mode,
    input  logic [XLEN-1:0]    base,
    input  logic [XLEN-1:0]    index,
    input  logic [XLEN-1:0]    pc,
    input  logic [IMM_W-1:0]   imm,
    input  logic [SCALE_W-1:0] scale,
    output logic [XLEN-1:0]    opa,
    output logic [XLEN-1:0]    opb
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_sx;
    assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};

    // Exactly two addends leave this block, whichever mode is selected.
    always_comb begin
        opa = base;
        opb = imm_sx;
        unique case (mode)
            AM_DISP: begin
                opa = base;
                opb = imm_sx;
            end
            AM_PCREL: begin
                opa = pc;
                opb = imm_sx << PC_SH;
            end
            AM_INDEX: begin
                opa = base;
                opb = index << scale;
            end
            AM_RSVD: begin
                opa = base;
                opb = imm_sx;
            end
        endcase
    end
endmodule

// File: rtl/ldst_adder.sv
module ldst_adder #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] sum
);
    // The carry out is dropped, so the sum wraps.
    assign sum = a + b;
endmodule

// File: rtl/ldst_rule_check.sv
module ldst_rule_check
    import ldst_addr_gen_pkg::*;
(
    input  addr_mode_e  mode,
    input  logic        store,
    input  acc_size_e   size,
    input  logic [1:0]  addr_lo,
    output logic        illegal,
    output logic        misalign
);
    always_comb begin
        illegal = 1'b0;
        unique case (mode)
            AM_DISP:  illegal = 1'b0;
            AM_PCREL: illegal = store || (size != SZ_WORD);
            AM_INDEX: illegal = store;
            AM_RSVD:  illegal = 1'b1;
        endcase
        if (size == SZ_RSVD) begin
            illegal = 1'b1;
        end
    end

    always_comb begin
        misalign = 1'b0;
        unique case (size)
            SZ_BYTE: misalign = 1'b0;
            SZ_HALF: misalign = addr_lo[0];
            SZ_WORD: misalign = |addr_lo;
            SZ_RSVD: misalign = 1'b0;
        endcase
    end
endmodule

// File: rtl/ldst_addr_gen.sv
module ldst_addr_gen
    import ldst_addr_gen_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int IMM_W   = 16,
    parameter int SCALE_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [1:0]         in_mode,
    input  logic               in_store,
    input  logic [XLEN-1:0]    in_base,
    input  logic [XLEN-1:0]    in_index,
    input  logic [XLEN-1:0]    in_pc,
    input  logic [IMM_W-1:0]   in_imm,
    input  logic [SCALE_W-1:0] in_scale,
    input  logic [1:0]         in_size,
    output logic [XLEN-1:0]    out_addr,
    output logic               out_valid,
    output logic               out_illegal,
    output logic               out_misalign
);
    addr_mode_e      mode_c;
    acc_size_e       size_c;
    logic [XLEN-1:0] opa;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] sum;
    logic            illegal_c;
    logic            misalign_c;
    out_state_e      state_q;
    out_state_e      state_d;
    logic [XLEN-1:0] addr_q;
    logic            illegal_q;
    logic            misalign_q;

    assign mode_c = addr_mode_e'(in_mode);
    assign size_c = acc_size_e'(in_size);

    ldst_operand_sel #(
        .XLEN   (XLEN),
        .IMM_W  (IMM_W),
        .SCALE_W(SCALE_W),
        .PC_SH  (2)
    ) u_sel (
        .mode (mode_c),
        .base (in_base),
        .index(in_index),
        .pc   (in_pc),
        .imm  (in_imm),
        .scale(in_scale),
        .opa  (opa),
        .opb  (opb)
    );

    ldst_adder #(.XLEN(XLEN)) u_add (
        .a  (opa),
        .b  (opb),
        .sum(sum)
    );

    ldst_rule_check u_chk (
        .mode    (mode_c),
        .store   (in_store),
        .size    (size_c),
        .addr_lo (sum[1:0]),
        .illegal (illegal_c),
        .misalign(misalign_c)
    );

    // Next-state logic: take on a strobe, drain otherwise.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_EMPTY: state_d = in_valid ? OS_FULL : OS_EMPTY;
            OS_FULL:  state_d = in_valid ? OS_FULL : OS_EMPTY;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= OS_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q     <= '0;
            illegal_q  <= 1'b0;
            misalign_q <= 1'b0;
        end else begin
            illegal_q  <= in_valid && illegal_c;
            misalign_q <= in_valid && misalign_c;
            if (in_valid) begin
                addr_q <= sum;
            end
        end
    end

    assign out_addr     = addr_q;
    assign out_valid    = (state_q == OS_FULL);
    assign out_illegal  = illegal_q;
    assign out_misalign = misalign_q;
endmodule

// File: rtl/ldst_addr_gen_checker.sv
module ldst_addr_gen_checker #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [1:0]       in_mode,
    input logic             in_store,
    input logic [XLEN-1:0]  in_base,
    input logic [IMM_W-1:0] in_imm,
    input logic [1:0]       in_size,
    input logic [XLEN-1:0]  out_addr,
    input logic             out_valid,
    input logic             out_illegal,
    input logic             out_misalign
);
    a_r9_valid_taken: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r9_valid_drained: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r11_flags_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_illegal && !out_misalign));

    a_r4_index_store: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'd2 && in_store) |=> (out_illegal && out_valid));

    a_r6_disp_legal: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'd0 && in_size != 2'd3) |=> !out_illegal);

    a_r1_disp_sum: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == 2'd0) |=>
        out_addr == $past(in_base + {{(XLEN-IMM_W){in_imm[IMM_W-1]}}, in_imm}));

    a_r7_word_align: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'd2) |=> (out_misalign == (out_addr[1:0] != 2'b00)));
endmodule

bind ldst_addr_gen ldst_addr_gen_checker #(
    .XLEN (XLEN),
    .IMM_W(IMM_W)
) u_ldst_addr_gen_checker (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_mode     (in_mode),
    .in_store    (in_store),
    .in_base     (in_base),
    .in_imm      (in_imm),
    .in_size     (in_size),
    .out_addr    (out_addr),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_misalign(out_misalign)
);

// File: tb/ldst_addr_gen_bench.sv
`timescale 1ns/1ps
module ldst_addr_gen_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_mode = '0;
    logic        in_store = 1'b0;
    logic [31:0] in_base = '0;
    logic [31:0] in_index = '0;
    logic [31:0] in_pc = '0;
    logic [15:0] in_imm = '0;
    logic [1:0]  in_scale = '0;
    logic [1:0]  in_size = '0;
    logic [31:0] out_addr;
    logic        out_valid;
    logic        out_illegal;
    logic        out_misalign;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ldst_addr_gen u_ldst_addr_gen (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_mode(in_mode),
        .in_store(in_store), .in_base(in_base), .in_index(in_index),
        .in_pc(in_pc), .in_imm(in_imm), .in_scale(in_scale), .in_size(in_size),
        .out_addr(out_addr), .out_valid(out_valid), .out_illegal(out_illegal),
        .out_misalign(out_misalign)
    );

    // Reference model: returns {valid, illegal, misalign, addr}.
    function automatic logic [34:0] model(input logic [1:0] m, input logic st,
            input logic [31:0] b, input logic [31:0] x, input logic [31:0] p,
            input logic [15:0] im, input logic [1:0] sc, input logic [1:0] sz);
        logic [31:0] sx;
        logic [31:0] a;
        logic        ill;
        logic        mis;
        sx = {{16{im[15]}}, im};
        case (m)
            2'd0: begin a = b + sx;         ill = 1'b0; end
            2'd1: begin a = p + (sx << 2);  ill = st || (sz != 2'd2); end
            2'd2: begin a = b + (x << sc);  ill = st; end
            default: begin a = b + sx;      ill = 1'b1; end
        endcase
        if (sz == 2'd3) ill = 1'b1;
        mis = (sz == 2'd1) ? a[0] : (sz == 2'd2) ? (a[1:0] != 2'b00) : 1'b0;
        return {1'b1, ill, mis, a};
    endfunction

    task automatic chk(input string tag, input logic [34:0] act, input logic [34:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual v=%0b ill=%0b mis=%0b addr=%08h expected v=%0b ill=%0b mis=%0b addr=%08h",
                tag, act[34], act[33], act[32], act[31:0], exp[34], exp[33], exp[32], exp[31:0]);
        end
    endtask

    task automatic op(input string tag, input logic [1:0] m, input logic st,
            input logic [31:0] b, input logic [31:0] x, input logic [31:0] p,
            input logic [15:0] im, input logic [1:0] sc, input logic [1:0] sz);
        @(negedge clk);
        in_valid = 1'b1; in_mode = m; in_store = st; in_base = b; in_index = x;
        in_pc = p; in_imm = im; in_scale = sc; in_size = sz;
        @(posedge clk); #2;
        chk(tag, {out_valid, out_illegal, out_misalign, out_addr},
            model(m, st, b, x, p, im, sc, sz));
    endtask

    task automatic idle(input string tag, input logic [31:0] held);
        @(negedge clk);
        in_valid = 1'b0; in_base = 32'h1357_9bdf; in_imm = 16'h7777;
        @(posedge clk); #2;
        chk(tag, {out_valid, out_illegal, out_misalign, out_addr}, {3'b000, held});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        chk("R10 reset", {out_valid, out_illegal, out_misalign, out_addr}, 35'd0);
        @(negedge clk); rst = 1'b0;

        op("R1 zero disp", 2'd0, 1'b0, 32'h0000_1000, 32'h0, 32'h0, 16'h0000, 2'd0, 2'd2);
        op("R1 negative disp", 2'd0, 1'b0, 32'h0000_1000, 32'h0, 32'h0, 16'hFFF0, 2'd0, 2'd2);
        op("R8 wrap", 2'd0, 1'b0, 32'hFFFF_FFFC, 32'h0, 32'h0, 16'h0008, 2'd0, 2'd2);
        op("R6 disp byte store", 2'd0, 1'b1, 32'h0000_2003, 32'h0, 32'h0, 16'h0000, 2'd0, 2'd0);
        op("R6 disp half store", 2'd0, 1'b1, 32'h0000_2002, 32'h0, 32'h0, 16'h0004, 2'd0, 2'd1);
        op("R2 pcrel word load", 2'd1, 1'b0, 32'h0, 32'h0, 32'h0040_0000, 16'hFFFF, 2'd0, 2'd2);
        op("R2 pcrel store illegal", 2'd1, 1'b1, 32'h0, 32'h0, 32'h0040_0000, 16'h0010, 2'd0, 2'd2);
        op("R2 pcrel byte illegal", 2'd1, 1'b0, 32'h0, 32'h0, 32'h0040_0000, 16'h0010, 2'd0, 2'd0);
        op("R3 scale 3 imm ignored", 2'd2, 1'b0, 32'h0001_0000, 32'h0000_0005, 32'h0, 16'hABCD, 2'd3, 2'd2);
        op("R3 scale 0", 2'd2, 1'b0, 32'h0001_0000, 32'h0000_0007, 32'h0, 16'h0000, 2'd0, 2'd0);
        op("R4 indexed store", 2'd2, 1'b1, 32'h0001_0000, 32'h0000_0004, 32'h0, 16'h0, 2'd2, 2'd2);
        op("R5 reserved mode", 2'd3, 1'b0, 32'h0000_0100, 32'h0, 32'h0, 16'h0, 2'd0, 2'd2);
        op("R5 reserved size", 2'd0, 1'b0, 32'h0000_0101, 32'h0, 32'h0, 16'h0, 2'd0, 2'd3);
        op("R7 half misalign", 2'd0, 1'b0, 32'h0000_0101, 32'h0, 32'h0, 16'h0, 2'd0, 2'd1);
        op("R7 word misalign", 2'd0, 1'b0, 32'h0000_0102, 32'h0, 32'h0, 16'h0, 2'd0, 2'd2);
        op("R11 flags with valid", 2'd2, 1'b1, 32'h0000_0101, 32'h1, 32'h0, 16'h0, 2'd0, 2'd2);
        idle("R9 R11 idle holds address", 32'h0000_0102);
        idle("R9 second idle", 32'h0000_0102);

        for (int i = 0; i < 400; i++) begin
            logic [1:0] m;
            logic [1:0] sz;
            m  = 2'($urandom_range(0, 3));
            sz = 2'($urandom_range(0, 3));
            op(m == 2'd0 ? "R1 random" : m == 2'd1 ? "R2 random" :
               m == 2'd2 ? "R3 random" : "R5 random",
               m, 1'($urandom), $urandom, $urandom, $urandom, 16'($urandom),
               2'($urandom), sz);
            if (i % 37 == 0) idle("R9 random idle", out_addr);
        end

        @(negedge clk); rst = 1'b1;
        @(posedge clk); #2;
        chk("R10 reset again", {out_valid, out_illegal, out_misalign, out_addr}, 35'd0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule